// File: doc/BRIEF.md
# Backlight PWM Generator with Commit-Latched Settings

This block produces a single pulse-width-modulated output for dimming a display backlight. Software sets it up through a small word-wide register bus. That bus carries a byte address and returns the current register contents on reads, so fields can be changed by read-modify-write. Three timing settings are programmed: a clock prescaler, a cycle length and a high width. All three are written into staging registers first. The running generator does not see them until software toggles a commit bit from 0 to 1. A separate enable bit starts and stops the output.

Each output cycle begins high. It stays high for a programmed number of prescaled ticks and then goes low for the rest of the cycle. Committed settings are held back until the running cycle ends, so a change of brightness never produces a shortened or stretched pulse. Both the period and the high width are stored as "count minus one". A high width that reaches or passes the period gives a steady high output.

Top module: `bl_pwm_top`

## Requirements
- R1: After a synchronous active-high reset, every mapped register reads 0 and `pwm_out` is low.
- R2: The register map is as follows, and every unused bit reads 0:
  - Enable bit: offset 0x00, bit 0.
  - Commit bit: offset 0x08, bit 0.
  - Prescaler: offset 0x10, bits 25:16 (10 bits).
  - Period: offset 0x14, bits 11:0 (12 bits).
  - High width: offset 0x14, bits 28:16 (13 bits).
  - Each register reads back the value last written into its fields.
  - Reads are selected by `bus_sel`=1 with `bus_we`=0, and `bus_rdata` holds the result from the following cycle.
- R3: A write to an offset outside the map changes no register, and a read from such an offset returns 0.
- R4: Writes to the staging prescaler, period or high-width fields do not change the output waveform until a commit occurs.
- R5: Settings are copied from staging only when the commit bit goes from 0 to 1. Writing 1 while the commit bit already holds 1 copies nothing.
- R6: With prescaler D, period P and high width H, where H < P:
  - One output cycle lasts (P+1)*(D+1) clocks.
  - The output is high for the first (H+1)*(D+1) clocks of each cycle.
- R7: When H >= P, the output stays high continuously while enabled.
- R8: While disabled, the output is low and the counters are held at zero. After enable is written to 1, the output rises one clock later and begins a full-width high phase.
- R9: Committed settings take effect at the next cycle boundary. The cycle that is running when the commit occurs completes with the old period and high width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| pwm_out | output | 1 | Registered backlight PWM output |

## Verification
The bench builds the block with its default field widths of 10, 12 and 13 bits. It then programs only small prescaler and period values, so each output cycle lasts at most 16 clocks and many cycles fit into a short run. Prescaler values from 0 to 3 exercise both the undivided path and the divided-tick path. High widths equal to the period and far beyond it reach the steady-high case. A commit placed in the middle of a running cycle shows whether the boundary deferral works. The full-width fields are reached only through read-back, using an all-ones write.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
  // Register byte offsets
  localparam int OFF_ENABLE = 'h00;
  localparam int OFF_COMMIT = 'h08;
  localparam int OFF_PRESC  = 'h10;
  localparam int OFF_SHAPE  = 'h14;

  // Field positions and default widths
  localparam int PRESC_LSB  = 16;
  localparam int PER_LSB    = 0;
  localparam int HIGH_LSB   = 16;
  localparam int DEF_DIV_W  = 10;
  localparam int DEF_PER_W  = 12;
  localparam int DEF_HIGH_W = 13;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ENABLE,
    SEL_COMMIT,
    SEL_PRESC,
    SEL_SHAPE
  } reg_sel_e;
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
  import bl_pwm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DIV_W  = DEF_DIV_W,
  parameter int PER_W  = DEF_PER_W,
  parameter int HIGH_W = DEF_HIGH_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              enable_o,
  output logic              commit_pulse_o,
  output logic [DIV_W-1:0]  div_cm_o,
  output logic [PER_W-1:0]  per_cm_o,
  output logic [HIGH_W-1:0] high_cm_o
);
  reg_sel_e           sel;
  logic               en_q;
  logic               commit_q;
  logic [DIV_W-1:0]   div_stg;
  logic [PER_W-1:0]   per_stg;
  logic [HIGH_W-1:0]  high_stg;
  logic [DATA_W-1:0]  rd_word;
  logic               wr_acc;
  logic               rd_acc;
  logic               unused_wbits;

  assign unused_wbits = ^bus_wdata;
  assign wr_acc = bus_sel & bus_we;
  assign rd_acc = bus_sel & ~bus_we;

  always_comb begin
    if (bus_addr == ADDR_W'(OFF_ENABLE))      sel = SEL_ENABLE;
    else if (bus_addr == ADDR_W'(OFF_COMMIT)) sel = SEL_COMMIT;
    else if (bus_addr == ADDR_W'(OFF_PRESC))  sel = SEL_PRESC;
    else if (bus_addr == ADDR_W'(OFF_SHAPE))  sel = SEL_SHAPE;
    else                                      sel = SEL_NONE;
  end

  always_comb begin
    rd_word = '0;
    case (sel)
      SEL_ENABLE: rd_word[0] = en_q;
      SEL_COMMIT: rd_word[0] = commit_q;
      SEL_PRESC:  rd_word[PRESC_LSB +: DIV_W] = div_stg;
      SEL_SHAPE: begin
        rd_word[PER_LSB +: PER_W]   = per_stg;
        rd_word[HIGH_LSB +: HIGH_W] = high_stg;
      end
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q           <= 1'b0;
      commit_q       <= 1'b0;
      div_stg        <= '0;
      per_stg        <= '0;
      high_stg       <= '0;
      div_cm_o       <= '0;
      per_cm_o       <= '0;
      high_cm_o      <= '0;
      commit_pulse_o <= 1'b0;
      bus_rdata      <= '0;
    end else begin
      commit_pulse_o <= 1'b0;
      if (rd_acc) bus_rdata <= rd_word;
      if (wr_acc) begin
        case (sel)
          SEL_ENABLE: en_q <= bus_wdata[0];
          SEL_COMMIT: begin
            commit_q <= bus_wdata[0];
            if (bus_wdata[0] && !commit_q) begin
              div_cm_o       <= div_stg;
              per_cm_o       <= per_stg;
              high_cm_o      <= high_stg;
              commit_pulse_o <= 1'b1;
            end
          end
          SEL_PRESC: div_stg <= bus_wdata[PRESC_LSB +: DIV_W];
          SEL_SHAPE: begin
            per_stg  <= bus_wdata[PER_LSB +: PER_W];
            high_stg <= bus_wdata[HIGH_LSB +: HIGH_W];
          end
          default: ;
        endcase
      end
    end
  end

  assign enable_o = en_q;
endmodule

// File: rtl/bl_pwm_prescaler.sv
module bl_pwm_prescaler #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [DIV_W-1:0] div_act,
  output logic [DIV_W-1:0] tcnt,
  output logic             tick
);
  assign tick = enable && (tcnt == div_act);

  always_ff @(posedge clk) begin
    if (rst || !enable) tcnt <= '0;
    else if (tick)      tcnt <= '0;
    else                tcnt <= tcnt + 1'b1;
  end
endmodule

// File: rtl/bl_pwm_core.sv
module bl_pwm_core #(
  parameter int DIV_W  = 10,
  parameter int PER_W  = 12,
  parameter int HIGH_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              tick,
  input  logic              commit_pulse,
  input  logic [DIV_W-1:0]  div_cm,
  input  logic [PER_W-1:0]  per_cm,
  input  logic [HIGH_W-1:0] high_cm,
  output logic [DIV_W-1:0]  div_act,
  output logic [PER_W-1:0]  per_act,
  output logic [HIGH_W-1:0] high_act,
  output logic [PER_W-1:0]  pcnt,
  output logic              pwm_q
);
  localparam int CMP_W = (PER_W > HIGH_W) ? PER_W : HIGH_W;

  logic pend;
  logic want;
  logic boundary;
  logic load;
  logic in_high;

  assign boundary = tick && (pcnt == per_act);
  assign want     = pend | commit_pulse;
  assign load     = want && (boundary || !enable);
  assign in_high  = CMP_W'(pcnt) <= CMP_W'(high_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= 1'b0;
      div_act  <= '0;
      per_act  <= '0;
      high_act <= '0;
      pcnt     <= '0;
      pwm_q    <= 1'b0;
    end else begin
      pend  <= want && !load;
      pwm_q <= enable && in_high;
      if (load) begin
        div_act  <= div_cm;
        per_act  <= per_cm;
        high_act <= high_cm;
      end
      if (!enable || boundary) pcnt <= '0;
      else if (tick)           pcnt <= pcnt + 1'b1;
    end
  end
endmodule

// File: rtl/bl_pwm_top.sv
module bl_pwm_top
  import bl_pwm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DIV_W  = DEF_DIV_W,
  parameter int PER_W  = DEF_PER_W,
  parameter int HIGH_W = DEF_HIGH_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pwm_out
);
  logic              en_w;
  logic              commit_pulse_w;
  logic [DIV_W-1:0]  div_cm_w;
  logic [PER_W-1:0]  per_cm_w;
  logic [HIGH_W-1:0] high_cm_w;
  logic [DIV_W-1:0]  div_act_w;
  logic [PER_W-1:0]  per_act_w;
  logic [HIGH_W-1:0] high_act_w;
  logic [DIV_W-1:0]  tcnt_w;
  logic [PER_W-1:0]  pcnt_w;
  logic              tick_w;

  bl_pwm_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .DIV_W(DIV_W), .PER_W(PER_W), .HIGH_W(HIGH_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .enable_o(en_w), .commit_pulse_o(commit_pulse_w),
    .div_cm_o(div_cm_w), .per_cm_o(per_cm_w), .high_cm_o(high_cm_w)
  );

  bl_pwm_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst(rst), .enable(en_w),
    .div_act(div_act_w), .tcnt(tcnt_w), .tick(tick_w)
  );

  bl_pwm_core #(.DIV_W(DIV_W), .PER_W(PER_W), .HIGH_W(HIGH_W)) u_core (
    .clk(clk), .rst(rst), .enable(en_w), .tick(tick_w),
    .commit_pulse(commit_pulse_w),
    .div_cm(div_cm_w), .per_cm(per_cm_w), .high_cm(high_cm_w),
    .div_act(div_act_w), .per_act(per_act_w), .high_act(high_act_w),
    .pcnt(pcnt_w), .pwm_q(pwm_out)
  );
endmodule

// File: rtl/bl_pwm_chk.sv
module bl_pwm_chk #(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 10,
  parameter int PER_W  = 12,
  parameter int HIGH_W = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              enable,
  input logic              pwm_out,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DIV_W-1:0]  tcnt,
  input logic [PER_W-1:0]  pcnt,
  input logic [DIV_W-1:0]  div_act,
  input logic [PER_W-1:0]  per_act,
  input logic [HIGH_W-1:0] high_act
);
  logic wrap;
  assign wrap = (tcnt == div_act) && (pcnt == per_act);

  assert_reset_low_R1: assert property (@(posedge clk) rst |=> !pwm_out);

  assert_unused_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata[31:29] == 3'b0) && (bus_rdata[15:12] == 4'b0));

  assert_tick_range_R6: assert property (@(posedge clk) disable iff (rst)
    tcnt <= div_act);

  assert_period_range_R6: assert property (@(posedge clk) disable iff (rst)
    pcnt <= per_act);

  assert_full_high_R7: assert property (@(posedge clk) disable iff (rst)
    (enable && (32'(high_act) >= 32'(per_act))) |=> pwm_out);

  assert_off_low_R8: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !pwm_out);

  assert_no_midcycle_load_R9: assert property (@(posedge clk) disable iff (rst)
    (enable && !wrap) |=> ($stable(per_act) && $stable(high_act) && $stable(div_act)));
endmodule

bind bl_pwm_top bl_pwm_chk #(
  .DATA_W(DATA_W), .DIV_W(DIV_W), .PER_W(PER_W), .HIGH_W(HIGH_W)
) u_chk (
  .clk(clk), .rst(rst), .enable(en_w), .pwm_out(pwm_out),
  .bus_rdata(bus_rdata), .tcnt(tcnt_w), .pcnt(pcnt_w),
  .div_act(div_act_w), .per_act(per_act_w), .high_act(high_act_w)
);

// File: tb/bl_pwm_top_tb.sv
module bl_pwm_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pwm_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rises = 0;
  int rise_at = 0;
  int period_len = 0;
  int high_len = 0;
  logic prev_out = 1'b0;
  logic done = 1'b0;

  // vector table: prescaler, period, high width, expected clocks per cycle, expected high clocks
  // expected 0 marks a steady-high case
  localparam int NV = 6;
  localparam int T_DIV [NV] = '{0, 2, 1, 3, 0, 0};
  localparam int T_PER [NV] = '{9, 4, 7, 2, 5, 3};
  localparam int T_HI  [NV] = '{3, 1, 6, 0, 5, 100};
  localparam int T_EPER[NV] = '{10, 15, 16, 12, 0, 0};
  localparam int T_EHI [NV] = '{4, 6, 14, 4, 0, 0};

  always #10 clk = ~clk;

  bl_pwm_top u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out)
  );

  // edge monitor, sampled on the falling clock edge
  always @(negedge clk) begin
    cyc <= cyc + 1;
    prev_out <= pwm_out;
    if (pwm_out && !prev_out) begin
      period_len <= cyc - rise_at;
      rise_at <= cyc;
      rises <= rises + 1;
    end
    if (!pwm_out && prev_out) high_len <= cyc - rise_at;
    if (cyc > 100000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_rises(input int n);
    int target;
    target = rises + n;
    for (int i = 0; i < 400 && rises < target; i++) @(negedge clk);
    #1;
  endtask

  task automatic measure(input string req, input int ep, input int eh);
    wait_rises(2);
    check(period_len == ep, {req, " period"}, period_len, ep);
    check(high_len == eh, {req, " high"}, high_len, eh);
  endtask

  task automatic cfg(input int d, input int p, input int h);
    wr(8'h10, 32'(d) << 16);
    wr(8'h14, (32'(h) << 16) | 32'(p));
  endtask

  initial begin
    logic [31:0] r;
    int hi_cnt;
    idle(5);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(8'h00, r); check(r == 0, "R1 enable reg", r, 0);
    rd(8'h08, r); check(r == 0, "R1 commit reg", r, 0);
    rd(8'h10, r); check(r == 0, "R1 prescaler reg", r, 0);
    rd(8'h14, r); check(r == 0, "R1 shape reg", r, 0);
    check(pwm_out == 1'b0, "R1 output", pwm_out, 0);

    // R2 field read-back with unused bits zero
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, r); check(r == 32'h03FF_0000, "R2 prescaler field", r, 32'h03FF_0000);
    wr(8'h14, 32'hFFFF_FFFF); rd(8'h14, r); check(r == 32'h1FFF_0FFF, "R2 shape fields", r, 32'h1FFF_0FFF);
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, r); check(r == 32'h1, "R2 enable bit", r, 1);
    wr(8'h00, 32'h0);         rd(8'h00, r); check(r == 32'h0, "R2 enable clear", r, 0);

    // R3 unmapped offsets
    wr(8'h04, 32'hFFFF_FFFF); wr(8'h0C, 32'hFFFF_FFFF); wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h04, r); check(r == 0, "R3 read 0x04", r, 0);
    rd(8'h18, r); check(r == 0, "R3 read 0x18", r, 0);
    rd(8'h00, r); check(r == 0, "R3 enable untouched", r, 0);
    rd(8'h10, r); check(r == 32'h03FF_0000, "R3 prescaler untouched", r, 32'h03FF_0000);
    idle(3);
    check(pwm_out == 1'b0, "R3 output still low", pwm_out, 0);

    // table walk, R6 and R7
    wr(8'h00, 32'h1);
    for (int v = 0; v < NV; v++) begin
      cfg(T_DIV[v], T_PER[v], T_HI[v]);
      wr(8'h08, 32'h1);
      rd(8'h08, r); check(r == 1, "R2 commit bit", r, 1);
      wr(8'h08, 32'h0);
      idle(40);
      if (T_EPER[v] != 0) begin
        measure("R6 table", T_EPER[v], T_EHI[v]);
      end else begin
        hi_cnt = 0;
        for (int i = 0; i < 30; i++) begin
          @(negedge clk);
          if (pwm_out) hi_cnt++;
        end
        check(hi_cnt == 30, "R7 steady high", hi_cnt, 30);
      end
    end

    // R4 staging without commit has no effect
    cfg(0, 9, 3); wr(8'h08, 1); wr(8'h08, 0); idle(40);
    measure("R4 baseline", 10, 4);
    cfg(1, 3, 0); idle(40);
    measure("R4 uncommitted", 10, 4);

    // R5 only a 0->1 commit transition applies
    wr(8'h08, 1); idle(40);
    measure("R5 first commit", 8, 2);
    cfg(0, 9, 3); wr(8'h08, 1); idle(40);
    measure("R5 repeated one", 8, 2);
    wr(8'h08, 0); wr(8'h08, 1); wr(8'h08, 0); idle(40);
    measure("R5 new edge", 10, 4);

    // R9 commit mid-cycle: running cycle completes unchanged
    wait_rises(1);
    wr(8'h14, (32'd1 << 16) | 32'd5);
    wr(8'h08, 1); wr(8'h08, 0);
    wait_rises(1);
    check(period_len == 10, "R9 old cycle period", period_len, 10);
    check(high_len == 4, "R9 old cycle high", high_len, 4);
    wait_rises(1);
    check(period_len == 6, "R9 new cycle period", period_len, 6);
    check(high_len == 2, "R9 new cycle high", high_len, 2);

    // R8 disable holds low, enable restarts a full cycle
    wr(8'h00, 0); idle(2);
    hi_cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pwm_out) hi_cnt++;
    end
    check(hi_cnt == 0, "R8 low while disabled", hi_cnt, 0);
    wr(8'h00, 1);
    check(pwm_out == 1'b0, "R8 output before restart", pwm_out, 0);
    @(negedge clk); #1;
    check(pwm_out == 1'b1, "R8 output rises one clock after enable", pwm_out, 1);
    idle(4); #1;
    check(high_len == 2, "R8 first high phase full width", high_len, 2);
    measure("R8 after restart", 6, 2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule